// File: doc/BRIEF.md
# Voice Channel Power-State Sequencer

This block holds the power state of a group of voice channels that share one serial PCM bus. For every channel it decides whether the channel is active or powered down, and it raises a single device-wide power-down flag when the whole group must stop. Its inputs are per-channel power-down request levels, a test-mode input, per-channel transmit and receive frame syncs, a bus-format select (eight-bit per-channel slots or one shared 32-bit word), a clock-ratio-valid indication and the bus bit clock itself.

All logic runs on a free-running reference clock. The bit clock, frame syncs, power-down requests and test input pass through two-flop synchronizers. Bit-clock rising edges are the time base for the request filters. Reference-clock counters time the sync-loss windows and the bit-clock watchdog. A channel goes down on a filtered request, on loss of both of its syncs, on loss of the bit clock or on a device-wide condition. It comes back only after the request has been released for a full filter window, a frame sync has arrived for it, and the clock ratio is reported valid.

Top module: `chan_power_seq`

## Requirements
- R1: With `tst` low, a channel powers down once its `pdn` bit has been high on `PDN_FILT` (default 16) consecutive synchronized `mclk` rising edges. A high pulse spanning fewer edges leaves `ch_active` unchanged.
- R2: A powered-down channel becomes active only after `pdn` has been low on `PDN_FILT` consecutive `mclk` rising edges and then a rising edge arrives on that channel's transmit or receive frame sync. Until that sync arrives, the channel stays down.
- R3: In eight-bit mode a channel powers down when neither its `fsx` nor its `fsr` bit has risen for `LOSS_FRAMES*FRAME_CYC` reference cycles. A channel whose receive sync alone keeps running stays active.
- R4: When synchronized `mclk` shows no transition for `MCLK_TO` reference cycles, `global_pd` goes to 1 and every channel goes down. When the clock returns, channels come back up on the next frame sync.
- R5: When all `pdn` bits are filtered high, `global_pd` is 1 and all channels are down.
- R6: When every relevant frame sync has been absent for its loss window, `global_pd` is 1. It returns to 0 on the next sync edge.
- R7: A channel never becomes active while `rate_ok` is 0. It powers up on the first frame sync after `rate_ok` returns to 1.
- R8: With `pcm32` = 1, the channel-0 syncs (`fsx[0]`, `fsr[0]`) govern all channels and the syncs of the other channels are ignored. The loss window is then `SYNC32_CYC` reference cycles.
- R9: After reset every `ch_active` bit is 0. While no bit clock runs, `global_pd` is 1.
- R10: While `tst` is high the request filters hold their state, so a `pdn` change does not alter any channel's power state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mclk | input | 1 | Bus bit clock, sampled on `clk` |
| pdn | input | NCH | Per-channel power-down request, high = down |
| tst | input | 1 | Test-mode input; freezes the request filters |
| fsx | input | NCH | Per-channel transmit frame sync |
| fsr | input | NCH | Per-channel receive frame sync |
| pcm32 | input | 1 | 1 = shared 32-bit word framed by channel 0, 0 = eight-bit slots |
| rate_ok | input | 1 | Bit-clock to frame-rate ratio reported valid |
| ch_active | output | NCH | Per-channel active flag, 1 = powered up |
| global_pd | output | 1 | Device-wide power-down flag |

## Verification
The bench toggles one channel's request for slightly less than, and then more than, the filter window. This separates a correct filter from one that reacts early or never reacts. It removes one sync and then both, which shows whether loss is judged on both directions together. It releases a request while that channel's syncs are held off, which shows that recovery waits for a frame. Stopping the bit clock, raising every request together and silencing every sync each drive the device-wide flag. In 32-bit mode, feeding only channel-0 syncs, and then only the other channels' syncs, shows which syncs count and which window length applies.

// File: rtl/pd_pkg.sv
`timescale 1ns/1ps
package pd_pkg;
   typedef enum logic {
      FMT_SLOT8  = 1'b0,
      FMT_WORD32 = 1'b1
   } bus_fmt_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/pd_edge_sync.sv
`timescale 1ns/1ps
module pd_edge_sync #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] lvl,
   output logic [W-1:0] rise,
   output logic [W-1:0] chg
);
   if (W < 1) begin : g_bad_w
      $error("pd_edge_sync: W must be at least 1");
   end

   logic [W-1:0] meta_q, s1_q, s2_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         s1_q   <= '0;
         s2_q   <= '0;
      end else begin
         meta_q <= din;
         s1_q   <= meta_q;
         s2_q   <= s1_q;
      end
   end

   assign lvl  = s1_q;
   assign rise = s1_q & ~s2_q;
   assign chg  = s1_q ^ s2_q;
endmodule

// File: rtl/pd_level_filter.sv
`timescale 1ns/1ps
module pd_level_filter #(
   parameter int N     = 16,
   parameter bit INIT  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic hold,
   input  logic din,
   output logic q
);
   localparam int CW = (N > 1) ? $clog2(N) : 1;

   if (N < 2) begin : g_bad_n
      $error("pd_level_filter: N must be at least 2");
   end

   logic [CW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q     <= INIT;
         run_q <= '0;
      end else if (hold) begin
         run_q <= '0;
      end else if (step) begin
         if (din == q) begin
            run_q <= '0;
         end else if (run_q == CW'(N - 1)) begin
            q     <= din;
            run_q <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   // R1
   filt_step_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(q));

   // R10
   filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> $stable(q));
endmodule

// File: rtl/pd_quiet_timer.sv
`timescale 1ns/1ps
module pd_quiet_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] limit,
   output logic         expired
);
   if (W < 1) begin : g_bad_w
      $error("pd_quiet_timer: W must be at least 1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '1;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (cnt_q < limit) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired = (cnt_q >= limit);

   // R3
   quiet_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && limit != '0) |=> !expired);
endmodule

// File: rtl/chan_power_seq.sv
`timescale 1ns/1ps
module chan_power_seq #(
   parameter int NCH         = 4,
   parameter int PDN_FILT    = 16,
   parameter int FRAME_CYC   = 12500,
   parameter int LOSS_FRAMES = 4,
   parameter int SYNC32_CYC  = 51200,
   parameter int MCLK_TO     = 1200
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           mclk,
   input  logic [NCH-1:0] pdn,
   input  logic           tst,
   input  logic [NCH-1:0] fsx,
   input  logic [NCH-1:0] fsr,
   input  logic           pcm32,
   input  logic           rate_ok,
   output logic [NCH-1:0] ch_active,
   output logic           global_pd
);
   import pd_pkg::*;

   localparam int LOSS_CYC = LOSS_FRAMES * FRAME_CYC;
   localparam int WIN_MAX  = int'(max_u(LOSS_CYC, SYNC32_CYC));
   localparam int TW       = $clog2(WIN_MAX + 1);
   localparam int MW       = $clog2(MCLK_TO + 1);
   localparam int SW       = 3 * NCH + 2;

   if (NCH < 1 || PDN_FILT < 2 || FRAME_CYC < 1 || LOSS_FRAMES < 1
       || SYNC32_CYC < 1 || MCLK_TO < 2) begin : g_bad_cfg
      $error("chan_power_seq: parameter out of range");
   end

   bus_fmt_e fmt;
   assign fmt = bus_fmt_e'(pcm32);

   logic [SW-1:0] s_lvl, s_rise, s_chg;
   logic [NCH-1:0] pdn_s, fsx_r, fsr_r;
   logic mclk_rise, mclk_chg, tst_s;

   pd_edge_sync #(.W(SW)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({tst, mclk, pdn, fsr, fsx}),
      .lvl  (s_lvl),
      .rise (s_rise),
      .chg  (s_chg)
   );

   assign fsx_r     = s_rise[NCH-1:0];
   assign fsr_r     = s_rise[2*NCH-1:NCH];
   assign pdn_s     = s_lvl[3*NCH-1:2*NCH];
   assign mclk_rise = s_rise[3*NCH];
   assign mclk_chg  = s_chg[3*NCH];
   assign tst_s     = s_lvl[3*NCH+1];

   logic mclk_lost;
   pd_quiet_timer #(.W(MW)) u_mclk_wd (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (mclk_chg),
      .limit  (MW'(MCLK_TO)),
      .expired(mclk_lost)
   );

   logic [TW-1:0] win;
   assign win = (fmt == FMT_WORD32) ? TW'(SYNC32_CYC) : TW'(LOSS_CYC);

   logic [NCH-1:0] fs_any, fs_evt, filt, sync_lost, lost_eff;
   assign fs_any = fsx_r | fsr_r;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign fs_evt[i] = (fmt == FMT_WORD32) ? fs_any[0] : fs_any[i];

      pd_level_filter #(.N(PDN_FILT), .INIT(1'b1)) u_filt (
         .clk  (clk),
         .rst_n(rst_n),
         .step (mclk_rise),
         .hold (tst_s),
         .din  (pdn_s[i]),
         .q    (filt[i])
      );

      pd_quiet_timer #(.W(TW)) u_sync_to (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (fs_evt[i]),
         .limit  (win),
         .expired(sync_lost[i])
      );

      assign lost_eff[i] = sync_lost[i] & ~fs_evt[i];
   end

   logic glob;
   assign glob = mclk_lost | (&filt) | (&lost_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_active <= '0;
         global_pd <= 1'b1;
      end else begin
         global_pd <= glob;
         for (int i = 0; i < NCH; i++) begin
            if (filt[i] || lost_eff[i] || glob) begin
               ch_active[i] <= 1'b0;
            end else if (fs_evt[i] && rate_ok) begin
               ch_active[i] <= 1'b1;
            end
         end
      end
   end

   for (genvar i = 0; i < NCH; i++) begin : g_chk
      // R1
      req_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
         filt[i] |=> !ch_active[i]);

      // R2
      up_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ch_active[i]) |-> $past(fs_evt[i]));

      // R7
      up_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ch_active[i]) |-> $past(rate_ok));
   end

   // R4
   mclk_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mclk_lost |=> (ch_active == '0) && global_pd);

   // R5
   all_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&filt) |=> global_pd);
endmodule

// File: tb/sim_chan_power_seq.sv
`timescale 1ns/1ps
module sim_chan_power_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mclk = 1'b0;
   logic mclk_en = 1'b0;
   logic [3:0] pdn = 4'h0;
   logic tst = 1'b0;
   logic [3:0] fsx = 4'h0, fsr = 4'h0;
   logic [3:0] fsx_en = 4'h0, fsr_en = 4'h0;
   logic pcm32 = 1'b0;
   logic rate_ok = 1'b0;
   logic [3:0] ch_active;
   logic global_pd;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   initial forever begin
      #20;
      if (mclk_en) mclk = ~mclk;
   end

   // frame syncs every 1000 ns, one bit-clock period wide
   initial forever begin
      #960;
      fsx = fsx_en;
      fsr = fsr_en;
      #40;
      fsx = 4'h0;
      fsr = 4'h0;
   end

   chan_power_seq #(
      .NCH(4), .PDN_FILT(16), .FRAME_CYC(100), .LOSS_FRAMES(4),
      .SYNC32_CYC(300), .MCLK_TO(24)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .mclk(mclk), .pdn(pdn), .tst(tst),
      .fsx(fsx), .fsr(fsr), .pcm32(pcm32), .rate_ok(rate_ok),
      .ch_active(ch_active), .global_pd(global_pd)
   );

   task automatic check(input string req, input logic [4:0] exp);
      @(negedge clk);
      total++;
      if ({global_pd, ch_active} !== exp) begin
         bad++;
         $display("FAIL %s: {global_pd,ch_active} got %b expected %b", req, {global_pd, ch_active}, exp);
      end
   endtask

   task automatic t_reset();
      #20;
      check("R9 reset", 5'b10000);
   endtask

   task automatic t_bringup();
      mclk_en = 1'b1; rate_ok = 1'b1; pdn = 4'h0;
      fsx_en = 4'hF; fsr_en = 4'hF;
      #5000;
      check("R2 initial power up", 5'b01111);
   endtask

   task automatic t_pdn_filter();
      pdn[1] = 1'b1; #400; pdn[1] = 1'b0;
      #1500;
      check("R1 short pulse ignored", 5'b01111);
      pdn[1] = 1'b1; #800;
      check("R1 long request", 5'b01101);
   endtask

   task automatic t_recover_needs_frame();
      fsx_en[1] = 1'b0; fsr_en[1] = 1'b0;
      pdn[1] = 1'b0;
      #2500;
      check("R2 no frame yet", 5'b01101);
      fsx_en[1] = 1'b1; fsr_en[1] = 1'b1;
      #2000;
      check("R2 frame restores", 5'b01111);
   endtask

   task automatic t_one_sync();
      fsx_en[2] = 1'b0;
      #8000;
      check("R3 one sync keeps up", 5'b01111);
      fsr_en[2] = 1'b0;
      #6000;
      check("R3 both syncs lost", 5'b01011);
      fsx_en[2] = 1'b1; fsr_en[2] = 1'b1;
      #2000;
      check("R3 syncs back", 5'b01111);
   endtask

   task automatic t_test_hold();
      tst = 1'b1; pdn[3] = 1'b1;
      #1600;
      check("R10 filter frozen", 5'b01111);
      tst = 1'b0;
      #1000;
      check("R10 released test", 5'b00111);
      pdn[3] = 1'b0;
      #2500;
      check("R10 channel back", 5'b01111);
   endtask

   task automatic t_mclk_loss();
      mclk_en = 1'b0;
      #600;
      check("R4 clock lost", 5'b10000);
      mclk_en = 1'b1;
      #3000;
      check("R4 clock back", 5'b01111);
   endtask

   task automatic t_all_pdn();
      pdn = 4'hF;
      #1000;
      check("R5 all requests", 5'b10000);
      pdn = 4'h0;
      #3000;
      check("R5 released", 5'b01111);
   endtask

   task automatic t_all_sync();
      fsx_en = 4'h0; fsr_en = 4'h0;
      #5000;
      check("R6 all syncs gone", 5'b10000);
      fsx_en = 4'hF; fsr_en = 4'hF;
      #2000;
      check("R6 syncs back", 5'b01111);
   endtask

   task automatic t_rate();
      pdn[0] = 1'b1;
      #1000;
      check("R7 channel 0 down", 5'b01110);
      rate_ok = 1'b0; pdn[0] = 1'b0;
      #3000;
      check("R7 ratio invalid", 5'b01110);
      rate_ok = 1'b1;
      #2000;
      check("R7 ratio valid", 5'b01111);
   endtask

   task automatic t_word32();
      pcm32 = 1'b1;
      fsx_en = 4'b0001; fsr_en = 4'b0001;
      #6000;
      check("R8 channel 0 syncs serve all", 5'b01111);
      @(negedge fsx[0]);
      fsx_en = 4'b1110; fsr_en = 4'b1110;
      #1500;
      check("R8 before window", 5'b01111);
      #2000;
      check("R8 window expired", 5'b10000);
      pcm32 = 1'b0;
      fsx_en = 4'hF; fsr_en = 4'hF;
      #2500;
      check("R8 back to slots", 5'b01111);
   endtask

   initial begin
      #1000000;
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #33;
      rst_n = 1'b1;
      t_reset();
      t_bringup();
      t_pdn_filter();
      t_recover_needs_frame();
      t_one_sync();
      t_test_hold();
      t_mclk_loss();
      t_all_pdn();
      t_all_sync();
      t_rate();
      t_word32();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule